// File: doc/BRIEF.md
# Buck Converter Protection Sequencer

This block sits between the PWM modulator and the gate drivers of a synchronous buck stage. It is the digital protection controller. The raw high-side and low-side gate requests pass through it. It gates them according to four conditions:
- a duty ceiling inside each switching period,
- cycle-by-cycle current limiting,
- under-voltage supervision,
- thermal shutdown.

The switching period is derived from an internal phase counter of `PERIOD_CLKS` clocks. That counter starts at phase 0 on the first clock after reset is released and runs freely after that.

Current limiting works on whole periods. If the over-current comparator reports while the low-side request is active, the next period carries no high-side pulse. The low-side gate keeps switching. A run of `TRIP_EVENTS` consecutive flagged periods trips a hiccup. In a hiccup, both gates are held low for `HICCUP_CLKS` clocks, then a one-clock restart request goes to the start-up sequencer and switching resumes.

Over-current hiccups are limited. The trip after `OC_RETRY_LIMIT` restarts latches the block off. Under-voltage hiccups have no limit. Over-temperature latches off at once. Only reset clears the latch.

Top module: `buck_fault_mgr`

## Requirements
- R1: While and right after reset, `latched_off` and `restart_req` are 0, and the block is running: `ls_en` follows `ls_req`, and `hs_en` follows `hs_req` at phase 0.
- R2: `hs_en` can be 1 only at phases 0 to `PERIOD_CLKS*4/5-1` of each period (0..15 for a 20-clock period). Phase 0 is the first clock after reset release.
- R3: `hs_en` is never 1 without `hs_req`, and `ls_en` is never 1 without `ls_req`.
- R4: A period is flagged when `oc_cmp` is 1 on any clock of it where `ls_req` is 1. A clock where `oc_cmp` is 1 but `ls_req` is 0 flags nothing, and the next period keeps its high-side pulses.
- R5: After a flagged period, `hs_en` is 0 for the whole next period while `ls_en` still follows `ls_req`. After a clean period, high-side pulses resume in the following period.
- R6: A trip happens at the end of the `TRIP_EVENTS`-th (4th) consecutive flagged period. A clean period resets the run, so 3 flagged, 1 clean and 3 flagged periods do not trip.
- R7: After an over-current trip, both gates are 0 for `HICCUP_CLKS` clocks starting at the first clock of the next period. Then `restart_req` is 1 for exactly one clock, which is the first running clock.
- R8: The first `OC_RETRY_LIMIT` (3) over-current trips each cause a hiccup. The next over-current trip sets `latched_off` in the first clock of the following period.
- R9: Under-voltage is watched only while `ss_done` is 1 and the block runs. `uv_cmp` high for `UV_DELAY_CLKS` (5) consecutive running clocks trips a hiccup from the next clock. Any number of such trips hiccup without latching, and they do not count toward the over-current limit.
- R10: `ot_flag` high on a clock sets `latched_off` and forces both gates to 0 from the next clock. This holds in any state, including during a hiccup.
- R11: Once set, `latched_off` stays 1 and both gates stay 0 until reset, whatever the inputs do. `restart_req` is never 1 while latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hs_req | input | 1 | Raw high-side gate request from the modulator |
| ls_req | input | 1 | Raw low-side gate request from the modulator |
| oc_cmp | input | 1 | Over-current comparator: switch node below the limit |
| uv_cmp | input | 1 | Feedback below the under-voltage threshold |
| ot_flag | input | 1 | Die over-temperature indication |
| ss_done | input | 1 | Soft start finished, from the start-up sequencer |
| hs_en | output | 1 | Gated high-side enable |
| ls_en | output | 1 | Gated low-side enable |
| restart_req | output | 1 | One-clock pulse asking the sequencer to restart soft start |
| latched_off | output | 1 | Block is shut down until reset |

## Verification
The assertions assume these things about the inputs:
- every input is synchronous to `clk`;
- `rst_n` is low from time zero.

Under those assumptions, the gate outputs are pure gating of the requests. The bench keeps to these assumptions by changing inputs only just after falling edges. It also keeps its own phase count from the reset release, so every flagged-period, hiccup and latch expectation is placed in a known period and clock.

// File: rtl/buck_fault_pkg.sv
package buck_fault_pkg;

    typedef enum logic [1:0] {
        FM_RUN     = 2'd0,
        FM_HICCUP  = 2'd1,
        FM_LATCHED = 2'd2
    } fm_state_e;

    // Highest number of clocks of a period that may carry a high-side pulse (80 %).
    function automatic int duty_ceiling(input int period_clks);
        return (period_clks * 4) / 5;
    endfunction

endpackage

// File: rtl/buck_period_timer.sv
module buck_period_timer #(
    parameter int PERIOD_CLKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_last,
    output logic on_window
);
    localparam int PW     = $clog2(PERIOD_CLKS);
    localparam int MAX_ON = buck_fault_pkg::duty_ceiling(PERIOD_CLKS);

    logic [PW-1:0] phase_d, phase_q;

    always_comb begin
        phase_last = (phase_q == PW'(PERIOD_CLKS - 1));
        on_window  = (phase_q < PW'(MAX_ON));
        phase_d    = phase_last ? '0 : phase_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/buck_oc_tracker.sv
module buck_oc_tracker #(
    parameter int TRIP_EVENTS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic phase_last,
    input  logic sample,
    output logic skip_pulse,
    output logic trip
);
    localparam int CW = $clog2(TRIP_EVENTS + 1);

    typedef struct packed {
        logic          seen;
        logic          skip;
        logic [CW-1:0] run;
    } oc_regs_t;

    oc_regs_t s_d, s_q;
    logic     event_now;

    always_comb begin
        s_d       = s_q;
        trip      = 1'b0;
        event_now = s_q.seen | sample;
        if (!enable) begin
            s_d = '0;
        end else if (phase_last) begin
            s_d.seen = 1'b0;
            s_d.skip = event_now;
            if (event_now) begin
                if (s_q.run == CW'(TRIP_EVENTS - 1)) begin
                    trip     = 1'b1;
                    s_d.run  = '0;
                end else begin
                    s_d.run  = s_q.run + CW'(1);
                end
            end else begin
                s_d.run = '0;
            end
        end else begin
            s_d.seen = event_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign skip_pulse = s_q.skip;
endmodule

// File: rtl/buck_uv_filter.sv
module buck_uv_filter #(
    parameter int UV_DELAY_CLKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic low_in,
    output logic trip
);
    localparam int CW = $clog2(UV_DELAY_CLKS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        trip  = 1'b0;
        if (enable && low_in) begin
            if (cnt_q == CW'(UV_DELAY_CLKS - 1)) trip = 1'b1;
            else                                 cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/buck_fault_mgr.sv
module buck_fault_mgr #(
    parameter int PERIOD_CLKS    = 20,
    parameter int TRIP_EVENTS    = 4,
    parameter int OC_RETRY_LIMIT = 3,
    parameter int UV_DELAY_CLKS  = 5,
    parameter int HICCUP_CLKS    = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_req,
    input  logic ls_req,
    input  logic oc_cmp,
    input  logic uv_cmp,
    input  logic ot_flag,
    input  logic ss_done,
    output logic hs_en,
    output logic ls_en,
    output logic restart_req,
    output logic latched_off
);
    import buck_fault_pkg::*;

    localparam int HW = $clog2(HICCUP_CLKS);
    localparam int RW = $clog2(OC_RETRY_LIMIT + 1);

    typedef struct packed {
        fm_state_e     st;
        logic [HW-1:0] hic;
        logic [RW-1:0] retries;
        logic          restart;
    } fm_regs_t;

    fm_regs_t f_d, f_q;
    logic     running, phase_last, on_window, skip_pulse, oc_trip, uv_trip;

    assign running = (f_q.st == FM_RUN);

    buck_period_timer #(.PERIOD_CLKS(PERIOD_CLKS)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_last (phase_last),
        .on_window  (on_window)
    );

    buck_oc_tracker #(.TRIP_EVENTS(TRIP_EVENTS)) u_oc (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (running),
        .phase_last (phase_last),
        .sample     (ls_req & oc_cmp),
        .skip_pulse (skip_pulse),
        .trip       (oc_trip)
    );

    buck_uv_filter #(.UV_DELAY_CLKS(UV_DELAY_CLKS)) u_uv (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (running & ss_done),
        .low_in (uv_cmp),
        .trip   (uv_trip)
    );

    always_comb begin
        f_d         = f_q;
        f_d.restart = 1'b0;
        if (ot_flag) begin
            f_d.st  = FM_LATCHED;
            f_d.hic = '0;
        end else begin
            unique case (f_q.st)
                FM_RUN: begin
                    if (oc_trip) begin
                        if (f_q.retries == RW'(OC_RETRY_LIMIT)) begin
                            f_d.st = FM_LATCHED;
                        end else begin
                            f_d.st      = FM_HICCUP;
                            f_d.retries = f_q.retries + RW'(1);
                            f_d.hic     = '0;
                        end
                    end else if (uv_trip) begin
                        f_d.st  = FM_HICCUP;
                        f_d.hic = '0;
                    end
                end
                FM_HICCUP: begin
                    if (f_q.hic == HW'(HICCUP_CLKS - 1)) begin
                        f_d.st      = FM_RUN;
                        f_d.hic     = '0;
                        f_d.restart = 1'b1;
                    end else begin
                        f_d.hic = f_q.hic + HW'(1);
                    end
                end
                default: f_d.st = FM_LATCHED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: FM_RUN, hic: '0, retries: '0, restart: 1'b0};
        else        f_q <= f_d;
    end

    assign hs_en       = running & on_window & ~skip_pulse & hs_req;
    assign ls_en       = running & ls_req;
    assign restart_req = f_q.restart;
    assign latched_off = (f_q.st == FM_LATCHED);
endmodule

// File: rtl/buck_fault_mgr_chk.sv
module buck_fault_mgr_chk #(
    parameter int PERIOD_CLKS = 20
) (
    input logic clk,
    input logic rst_n,
    input logic hs_req,
    input logic ls_req,
    input logic ot_flag,
    input logic hs_en,
    input logic ls_en,
    input logic restart_req,
    input logic latched_off
);
    localparam int MAX_ON = buck_fault_pkg::duty_ceiling(PERIOD_CLKS);
    localparam int CW     = $clog2(PERIOD_CLKS + 1);

    logic [CW-1:0] hs_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     hs_run_q <= '0;
        else if (hs_en) hs_run_q <= hs_run_q + CW'(1);
        else            hs_run_q <= '0;
    end

    // R2
    duty_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (hs_run_q < CW'(MAX_ON)));

    // R3
    hs_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> hs_req);

    // R3
    ls_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_en |-> ls_req);

    // R7
    restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);

    // R10
    thermal_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |=> latched_off);

    // R11
    latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latched_off |=> latched_off);

    // R11
    latch_gates_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        latched_off |-> (!hs_en && !ls_en && !restart_req));
endmodule

bind buck_fault_mgr buck_fault_mgr_chk #(.PERIOD_CLKS(PERIOD_CLKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hs_req      (hs_req),
    .ls_req      (ls_req),
    .ot_flag     (ot_flag),
    .hs_en       (hs_en),
    .ls_en       (ls_en),
    .restart_req (restart_req),
    .latched_off (latched_off)
);

// File: tb/buck_fault_mgr_tb.sv
module buck_fault_mgr_tb;
    localparam int PERIOD = 20;
    localparam int MAXON  = 16;
    localparam int RETRY  = 3;
    localparam int UVD    = 5;
    localparam int HIC    = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_req = 0, ls_req = 0, oc_cmp = 0, uv_cmp = 0, ot_flag = 0, ss_done = 0;
    logic hs_en, ls_en, restart_req, latched_off;

    int checks = 0;
    int errors = 0;
    int ph = 0;

    always #10 clk = ~clk;

    buck_fault_mgr #(
        .PERIOD_CLKS(PERIOD), .TRIP_EVENTS(4), .OC_RETRY_LIMIT(RETRY),
        .UV_DELAY_CLKS(UVD), .HICCUP_CLKS(HIC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
        .oc_cmp(oc_cmp), .uv_cmp(uv_cmp), .ot_flag(ot_flag), .ss_done(ss_done),
        .hs_en(hs_en), .ls_en(ls_en), .restart_req(restart_req), .latched_off(latched_off)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (phase %0d, t=%0t)", req, act, exp, ph, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        ph = (ph + 1) % PERIOD;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hs_req = 0; ls_req = 0; oc_cmp = 0; uv_cmp = 0; ot_flag = 0; ss_done = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 latched in reset", latched_off, 0);
        check("R1 restart in reset", restart_req, 0);
        @(negedge clk);
        rst_n = 1'b1;
        hs_req = 1; ls_req = 1;
        ph = 0;
        #1;
    endtask

    task automatic align();
        while (ph != 0) tick();
        #1;
    endtask

    // One full period from phase 0; oc event at phase 5, optionally with ls_req low.
    task automatic run_period(input bit oc5, input bit ls_low5, input bit exp_skip, input string req);
        for (int p = 0; p < PERIOD; p++) begin
            oc_cmp = oc5 && (p == 5);
            ls_req = !(ls_low5 && (p == 5));
            #1;
            check(req, hs_en, (!exp_skip && p < MAXON) ? 1 : 0);
            check(req, ls_en, ls_req);
            tick();
        end
        oc_cmp = 0;
        ls_req = 1;
        #1;
    endtask

    task automatic oc_four(input string req);
        run_period(1, 0, 0, req);
        run_period(1, 0, 1, req);
        run_period(1, 0, 1, req);
        run_period(1, 0, 1, req);
    endtask

    // Positioned at the first hiccup clock; ends at the first running clock.
    task automatic hiccup_pass(input string req);
        for (int i = 0; i < HIC; i++) begin
            oc_cmp = (i % 3 == 0);
            #1;
            check(req, {hs_en, ls_en, restart_req, latched_off}, 0);
            tick();
        end
        oc_cmp = 0;
        #1;
        check(req, restart_req, 1);
        check(req, ls_en, 1);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: got 1 expected 0 (run did not finish)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1
        check("R1 latched after reset", latched_off, 0);
        check("R1 restart after reset", restart_req, 0);
        check("R1 hs at phase 0", hs_en, 1);
        check("R1 ls follows", ls_en, 1);

        // R2 full phase sweep, R3 gating
        run_period(0, 0, 0, "R2 duty window");
        hs_req = 0;
        #1;
        check("R3 hs needs request", hs_en, 0);
        hs_req = 1;
        #1;

        // R4 comparator with low-side off is ignored
        run_period(1, 1, 0, "R4 ignored period");
        run_period(0, 0, 0, "R4 next period unskipped");

        // R5 skip one period, then resume
        run_period(1, 0, 0, "R5 flagged period");
        run_period(0, 0, 1, "R5 skipped period");
        run_period(0, 0, 0, "R5 resumed period");

        // R6 3 flagged + clean + 3 flagged: no trip
        run_period(1, 0, 0, "R6 run a");
        run_period(1, 0, 1, "R6 run a");
        run_period(1, 0, 1, "R6 run a");
        run_period(0, 0, 1, "R6 clean");
        run_period(1, 0, 0, "R6 run b");
        run_period(1, 0, 1, "R6 run b");
        run_period(1, 0, 1, "R6 run b");
        run_period(0, 0, 1, "R6 no trip");
        check("R6 not latched", latched_off, 0);

        // R7/R8 trips 1..3 hiccup, 4th latches
        for (int t = 0; t < RETRY; t++) begin
            oc_four("R8 trip run");
            hiccup_pass("R7 hiccup");
            check("R8 not latched after retry", latched_off, 0);
        end
        oc_four("R8 last run");
        check("R8 latched on 4th trip", latched_off, 1);
        for (int i = 0; i < 100; i++) begin
            oc_cmp = i[0]; uv_cmp = i[1]; ss_done = 1;
            #1;
            check("R11 latch holds", {latched_off, hs_en, ls_en, restart_req}, 4'b1000);
            tick();
        end
        oc_cmp = 0; uv_cmp = 0;

        do_reset();
        check("R11 reset clears latch", latched_off, 0);

        // R9 no supervision before soft start done
        uv_cmp = 1;
        for (int i = 0; i < 30; i++) begin
            #1;
            check("R9 ignored without ss_done", ls_en, 1);
            tick();
        end
        // R9 short low pulse does not trip
        ss_done = 1;
        for (int i = 0; i < UVD - 1; i++) tick();
        uv_cmp = 0;
        for (int i = 0; i < 10; i++) begin
            #1;
            check("R9 short dip ignored", ls_en, 1);
            tick();
        end
        // R9 five trips, never latched
        uv_cmp = 1;
        for (int t = 0; t < 5; t++) begin
            for (int k = 1; k <= UVD; k++) begin
                #1;
                check("R9 running before trip", ls_en, 1);
                if (k == 1 && t > 0) check("R9 restart pulse", restart_req, 1);
                tick();
            end
            #1;
            check("R9 tripped gates", {ls_en, hs_en, latched_off}, 0);
            for (int i = 1; i < HIC; i++) begin
                tick();
                #1;
                check("R9 hiccup off", ls_en, 0);
            end
            tick();
            if (t == 4) uv_cmp = 0;
        end
        #1;
        check("R9 restart after fifth", restart_req, 1);
        check("R9 unlimited not latched", latched_off, 0);
        // R9 UV trips left the OC retry budget intact
        align();
        run_period(0, 0, 0, "R9 clean");
        for (int t = 0; t < RETRY; t++) begin
            oc_four("R9 oc run");
            hiccup_pass("R9 oc hiccup");
        end
        oc_four("R9 oc final");
        check("R9 budget intact then R8 latch", latched_off, 1);

        // R10 thermal while running
        do_reset();
        repeat (7) tick();
        ot_flag = 1;
        tick();
        ot_flag = 0;
        #1;
        check("R10 latched next clock", latched_off, 1);
        check("R10 gates off", {hs_en, ls_en}, 0);
        repeat (5) tick();
        #1;
        check("R10 stays latched", latched_off, 1);

        // R10 thermal during hiccup
        do_reset();
        oc_four("R10 trip run");
        repeat (10) tick();
        ot_flag = 1;
        tick();
        ot_flag = 0;
        #1;
        check("R10 latched from hiccup", latched_off, 1);
        for (int i = 0; i < 60; i++) begin
            #1;
            check("R11 no restart while latched", {restart_req, ls_en, latched_off}, 3'b001);
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule